// File: doc/BRIEF.md
# Clock-Select Setup Register with Restart Interlock

This block is the CPU-facing setup register of a network controller core that picks the protocol clock rate. Software writes one byte that carries a two-bit clock multiplier select, an enhanced-mode enable, a line-idle bypass bit and a fast-read enable. The select starts at the base rate after reset. A legal change of the select stops the protocol core at once and powers up the clock-multiplier PLL. A lock timer then counts the PLL settling time on the reference clock.

The core stays stopped until software writes the restart code 18h into the command port. If that restart arrives before the lock timer has finished, the core still restarts, but a sticky warning flag is set. Only one change of the select is accepted per reset. The reserved select code is refused outright. Selecting the top rate without enhanced mode raises a configuration-error output. The fast-read enable only takes effect when the external bus-timing pin is also high.

Top module: `clkcfg_setup`

## Requirements
- R1: After reset the select is 00, the core runs, the PLL power-up is low, and the lock flag and the early-restart flag are low. The setup readback is 00h.
- R2: The readback layout is: bit 0 is the fast-read bit, bit 1 is enhanced mode, bit 2 is the line-idle bypass, and bits 5:4 are the clock select. Bits 3, 6 and 7 always read 0. The three flag bits take the written value on every setup write.
- R3: A setup write whose select (01 = x2, 11 = x4) differs from the current one, when no change has been accepted since reset, updates the select, clears the core-run output and raises PLL power-up, all at the same clock edge.
- R4: A write of select code 10 (reserved) leaves the select unchanged, does not stop the core, and does not use up the single allowed change.
- R5: Once a change has been accepted, any later select value is ignored until reset.
- R6: Writing the select value that is already held has no effect on the core and does not use up the allowed change.
- R7: The lock flag rises exactly LOCK_CYCLES clock edges after the edge that accepted the change. PLL power-up stays high until reset.
- R8: Only a command write of 18h restarts a stopped core. Other codes leave it stopped. 18h has no effect on a running core.
- R9: A restart accepted while the lock flag is low sets the early-restart flag, which then stays set until reset. A restart after lock leaves the flag low.
- R10: The configuration-error output is high exactly when the select is 11 and enhanced mode is 0.
- R11: The fast-read output equals the fast-read bit AND the bus-timing pin.
- R12: The line-idle-required output is the inverse of the line-idle bypass bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_wdata | input | 8 | Setup register write data |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command register write data |
| bus_fast_pin | input | 1 | External bus-timing strap |
| cfg_rdata | output | 8 | Setup register readback |
| ratio_sel | output | 2 | Selected clock multiplier code |
| core_run | output | 1 | Protocol core run enable |
| pll_pwr_up | output | 1 | Clock-multiplier PLL power-up |
| pll_locked | output | 1 | Lock timer expired |
| early_restart | output | 1 | Sticky restart-before-lock warning |
| cfg_error | output | 1 | Top rate selected without enhanced mode |
| fast_read_en | output | 1 | Gated high-speed read enable |
| enh_mode | output | 1 | Enhanced functions enable |
| line_idle_req | output | 1 | Line must be idle for RAM initialisation |

## Verification
The bench sweeps every setup byte from reset and every ordered pair of select codes. This catches three kinds of fault: a design that accepts the reserved code, one that counts a refused or same-value write as the single allowed change, and one that lets a second change through. The lock flag is sampled one cycle before and on its expected edge, so an off-by-one timer shows up. Restart handling is tested with wrong command codes, a restart before lock and a restart after lock. This exposes a design that resumes on any code, forgets the sticky warning, or raises it falsely.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic [1:0] {
        CK_BASE   = 2'b00,
        CK_DOUBLE = 2'b01,
        CK_RSVD   = 2'b10,
        CK_QUAD   = 2'b11
    } ck_sel_e;

    typedef struct packed {
        logic    fast_rd;
        logic    enh;
        logic    nosync;
        ck_sel_e sel;
    } setup_t;

    localparam logic [7:0] RESTART_CODE = 8'h18;
    localparam int BIT_FAST   = 0;
    localparam int BIT_ENH    = 1;
    localparam int BIT_NOSYNC = 2;
    localparam int SEL_LO     = 4;

    localparam setup_t SETUP_RESET = '{fast_rd: 1'b0, enh: 1'b0, nosync: 1'b0, sel: CK_BASE};

    function automatic logic sel_legal(input logic [1:0] s);
        return s != CK_RSVD;
    endfunction

    function automatic logic over_5m(input ck_sel_e s);
        return s == CK_QUAD;
    endfunction

    function automatic logic [7:0] pack_setup(input setup_t s);
        logic [7:0] r;
        r = 8'h00;
        r[BIT_FAST]           = s.fast_rd;
        r[BIT_ENH]            = s.enh;
        r[BIT_NOSYNC]         = s.nosync;
        r[SEL_LO+1:SEL_LO]    = s.sel;
        return r;
    endfunction

endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output setup_t     cfg,
    output logic       change_req
);
    logic    once_used;
    ck_sel_e new_sel;

    assign new_sel    = ck_sel_e'(wdata[SEL_LO+1:SEL_LO]);
    assign change_req = wr_en && !once_used && sel_legal(new_sel) && (new_sel != cfg.sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= SETUP_RESET;
            once_used <= 1'b0;
        end else begin
            if (wr_en) begin
                cfg.fast_rd <= wdata[BIT_FAST];
                cfg.enh     <= wdata[BIT_ENH];
                cfg.nosync  <= wdata[BIT_NOSYNC];
            end
            if (change_req) begin
                cfg.sel   <= new_sel;
                once_used <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/clksel_lock_timer.sv
module clksel_lock_timer #(
    parameter int LOCK_CYCLES = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pll_pwr,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pll_pwr <= 1'b0;
            locked  <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            pll_pwr <= 1'b1;
            locked  <= 1'b0;
            cnt     <= '0;
        end else if (pll_pwr && !locked) begin
            if (cnt == LAST) locked <= 1'b1;
            else             cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clksel_run_ctl.sv
module clksel_run_ctl
    import clksel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_req,
    input  logic       cmd_we,
    input  logic [7:0] cmd_data,
    input  logic       locked,
    output logic       core_run,
    output logic       early_flag
);
    logic restart_hit;
    assign restart_hit = cmd_we && (cmd_data == RESTART_CODE) && !core_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            core_run   <= 1'b1;
            early_flag <= 1'b0;
        end else if (halt_req) begin
            core_run <= 1'b0;
        end else if (restart_hit) begin
            core_run <= 1'b1;
            if (!locked) early_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/clkcfg_setup.sv
module clkcfg_setup
    import clksel_pkg::*;
#(
    parameter int LOCK_CYCLES = 160
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       cmd_we,
    input  logic [7:0] cmd_wdata,
    input  logic       bus_fast_pin,
    output logic [7:0] cfg_rdata,
    output logic [1:0] ratio_sel,
    output logic       core_run,
    output logic       pll_pwr_up,
    output logic       pll_locked,
    output logic       early_restart,
    output logic       cfg_error,
    output logic       fast_read_en,
    output logic       enh_mode,
    output logic       line_idle_req
);
    setup_t cfg;
    logic   change_req;

    clksel_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_we),
        .wdata      (cfg_wdata),
        .cfg        (cfg),
        .change_req (change_req)
    );

    clksel_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (change_req),
        .pll_pwr (pll_pwr_up),
        .locked  (pll_locked)
    );

    clksel_run_ctl u_run (
        .clk        (clk),
        .rst        (rst),
        .halt_req   (change_req),
        .cmd_we     (cmd_we),
        .cmd_data   (cmd_wdata),
        .locked     (pll_locked),
        .core_run   (core_run),
        .early_flag (early_restart)
    );

    assign cfg_rdata     = pack_setup(cfg);
    assign ratio_sel     = cfg.sel;
    assign cfg_error     = over_5m(cfg.sel) && !cfg.enh;
    assign fast_read_en  = cfg.fast_rd && bus_fast_pin;
    assign enh_mode      = cfg.enh;
    assign line_idle_req = !cfg.nosync;
endmodule

// File: rtl/clkcfg_setup_chk.sv
module clkcfg_setup_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic       cmd_we,
    input logic [7:0] cmd_wdata,
    input logic       bus_fast_pin,
    input logic [7:0] cfg_rdata,
    input logic [1:0] ratio_sel,
    input logic       core_run,
    input logic       pll_pwr_up,
    input logic       pll_locked,
    input logic       early_restart,
    input logic       cfg_error,
    input logic       fast_read_en,
    input logic       enh_mode,
    input logic       line_idle_req
);
    logic [1:0] prev_sel;
    logic       seen_change;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sel    <= 2'b00;
            seen_change <= 1'b0;
        end else begin
            prev_sel <= ratio_sel;
            if (ratio_sel != prev_sel) seen_change <= 1'b1;
        end
    end

    assert_halt_on_change_R3: assert property (@(posedge clk) disable iff (rst)
        (ratio_sel != prev_sel) |-> (!core_run && pll_pwr_up));

    assert_no_reserved_R4: assert property (@(posedge clk) disable iff (rst)
        ratio_sel != 2'b10);

    assert_single_change_R5: assert property (@(posedge clk) disable iff (rst)
        seen_change |-> (ratio_sel == prev_sel));

    assert_pll_stays_up_R7: assert property (@(posedge clk) disable iff (rst)
        pll_pwr_up |=> pll_pwr_up);

    assert_lock_needs_power_R7: assert property (@(posedge clk) disable iff (rst)
        pll_locked |-> pll_pwr_up);

    assert_restart_code_R8: assert property (@(posedge clk) disable iff (rst)
        (!core_run ##1 core_run) |-> $past(cmd_we && cmd_wdata == 8'h18));

    assert_early_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        early_restart |=> early_restart);

    assert_fast_gate_R11: assert property (@(posedge clk) disable iff (rst)
        fast_read_en |-> (bus_fast_pin && cfg_rdata[0]));
endmodule

bind clkcfg_setup clkcfg_setup_chk u_chk (.*);

// File: tb/clkcfg_setup_test.sv
`timescale 1ns/1ps
module clkcfg_setup_test;
    localparam int LOCK = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       bus_fast_pin = 1'b0;
    logic [7:0] cfg_rdata;
    logic [1:0] ratio_sel;
    logic       core_run, pll_pwr_up, pll_locked, early_restart;
    logic       cfg_error, fast_read_en, enh_mode, line_idle_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    clkcfg_setup #(.LOCK_CYCLES(LOCK)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .bus_fast_pin(bus_fast_pin),
        .cfg_rdata(cfg_rdata), .ratio_sel(ratio_sel), .core_run(core_run),
        .pll_pwr_up(pll_pwr_up), .pll_locked(pll_locked),
        .early_restart(early_restart), .cfg_error(cfg_error),
        .fast_read_en(fast_read_en), .enh_mode(enh_mode),
        .line_idle_req(line_idle_req)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wr_cmd(input logic [7:0] v);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    function automatic logic [1:0] step_sel(input logic [1:0] cur, input logic [1:0] nw,
                                            inout logic used);
        if (!used && nw != 2'b10 && nw != cur) begin
            used = 1'b1;
            return nw;
        end
        return cur;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check(ratio_sel == 2'b00, "R1 sel", ratio_sel, 0);
        check(core_run == 1'b1, "R1 run", core_run, 1);
        check(pll_pwr_up == 1'b0 && pll_locked == 1'b0, "R1 pll", {pll_pwr_up, pll_locked}, 0);
        check(early_restart == 1'b0, "R1 early", early_restart, 0);
        check(cfg_rdata == 8'h00, "R1 readback", cfg_rdata, 0);

        // R8: restart code on running core has no effect
        wr_cmd(8'h18);
        check(core_run == 1'b1 && early_restart == 1'b0, "R8 running 18h",
              {core_run, early_restart}, 2);

        // R2 R3 R10 R12: every setup byte from reset
        for (int v = 0; v < 256; v++) begin
            logic [1:0] es;
            logic [7:0] erd;
            logic       chg;
            do_reset();
            wr_cfg(v[7:0]);
            es  = (v[5:4] == 2'b10) ? 2'b00 : v[5:4];
            chg = (es != 2'b00);
            erd = {2'b00, es, 1'b0, v[2:0]};
            check(cfg_rdata == erd, "R2 readback", cfg_rdata, erd);
            check(core_run == !chg, "R3 halt", core_run, !chg);
            check(pll_pwr_up == chg, "R3 pll up", pll_pwr_up, chg);
            check(cfg_error == (es == 2'b11 && !v[1]), "R10 cfg error",
                  cfg_error, (es == 2'b11 && !v[1]));
            check(line_idle_req == !v[2], "R12 idle req", line_idle_req, !v[2]);
            check(enh_mode == v[1], "R2 enh", enh_mode, v[1]);
        end

        // R4 R5 R6: all ordered pairs of select codes
        for (int t = 0; t < 4; t++) begin
            for (int s = 0; s < 4; s++) begin
                logic [1:0] cur;
                logic       used;
                logic       used_first;
                cur  = 2'b00; used = 1'b0;
                do_reset();
                wr_cfg({2'b00, t[1:0], 4'h0});
                cur = step_sel(cur, t[1:0], used);
                used_first = used;
                wr_cfg({2'b00, s[1:0], 4'h0});
                cur = step_sel(cur, s[1:0], used);
                if (s == 2)
                    check(ratio_sel == cur, "R4 reserved", ratio_sel, cur);
                else if (used_first)
                    check(ratio_sel == cur, "R5 once only", ratio_sel, cur);
                else
                    check(ratio_sel == cur, "R6 same value", ratio_sel, cur);
                check(core_run == !used, "R4 R5 R6 run", core_run, !used);
            end
        end

        // R7 lock timing, then R9 restart after lock
        do_reset();
        wr_cfg(8'h10);
        repeat (LOCK - 1) @(negedge clk);
        check(pll_locked == 1'b0, "R7 before lock", pll_locked, 0);
        @(negedge clk);
        check(pll_locked == 1'b1, "R7 lock edge", pll_locked, 1);
        check(pll_pwr_up == 1'b1, "R7 pll held", pll_pwr_up, 1);
        wr_cmd(8'h18);
        check(core_run == 1'b1, "R8 restart", core_run, 1);
        check(early_restart == 1'b0, "R9 no early", early_restart, 0);

        // R8 wrong codes, R9 early restart sticky
        do_reset();
        wr_cfg(8'h32);
        check(cfg_error == 1'b0, "R10 enh set", cfg_error, 0);
        wr_cmd(8'h00); check(core_run == 1'b0, "R8 code 00", core_run, 0);
        wr_cmd(8'h10); check(core_run == 1'b0, "R8 code 10", core_run, 0);
        wr_cmd(8'h19); check(core_run == 1'b0, "R8 code 19", core_run, 0);
        wr_cmd(8'h81); check(core_run == 1'b0, "R8 code 81", core_run, 0);
        wr_cmd(8'h18);
        check(core_run == 1'b1, "R8 restart early", core_run, 1);
        check(early_restart == 1'b1, "R9 early set", early_restart, 1);
        repeat (LOCK + 2) @(negedge clk);
        wr_cmd(8'h18);
        check(early_restart == 1'b1 && core_run == 1'b1, "R9 sticky",
              {early_restart, core_run}, 3);

        // R11 fast read gating
        for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < 2; p++) begin
                do_reset();
                wr_cfg({7'h00, f[0]});
                bus_fast_pin = p[0];
                #1;
                check(fast_read_en == (f[0] & p[0]), "R11 fast read",
                      fast_read_en, f[0] & p[0]);
            end
        end
        bus_fast_pin = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule